// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Controller

This block controls one port of sixteen general-purpose pins from a 32-bit register interface. Software programs a 2-bit mode per pin (input, output, alternate function, analog), an output style (push-pull or open-drain), a pull selection, and a 4-bit alternate-function selector per pin. In output mode a pin follows a stored output data register. In alternate-function mode it follows one of sixteen peripheral sources chosen by its selector. Pad inputs pass through a two-flop synchronizer before software can read them.

The output data register can be changed as a whole. It can also be changed atomically through a set/clear register, where a set request beats a clear request for the same pin, and through a clear-only register. No read-modify-write sequence is needed. The bus side is a simple slave. Writes land on the rising clock edge where `bus_we` is high, with `bus_be` qualifying each byte. A read is requested with `bus_re`, and the data appears on `bus_rdata` one cycle later. `bus_rdata` holds its value until the next read. The asynchronous reset is released synchronously inside the block.

Top module: `gpio_port`

## Requirements
- R1: After reset the mode register (offset 0x00) reads 0xFFFFFFFF, so every pin is analog with its output enable low. Every other register reads zero.
- R2: The mode field of pin y is bits 2y+1:2y of offset 0x00, coded 00 input, 01 output, 10 alternate, 11 analog. `pad_oe[y]` can be high only in codes 01 and 10.
- R3: In mode 10 the selected value of pin y is `af_src[16*y + s]`, where s is the 4-bit field at bits 4(y mod 8)+3:4(y mod 8). That field is at offset 0x20 for pins 0-7 and at offset 0x24 for pins 8-15. In every other mode the selected value is output-data bit y.
- R4: Bit y of offset 0x04 set to 1 makes pin y open-drain. `pad_out[y]` is then 0, and `pad_oe[y]` is high only when the pin is in mode 01 or 10 and its selected value is 0. With the bit at 0, `pad_out[y]` equals the selected value, and `pad_oe[y]` is high in modes 01 and 10.
- R5: The pull field of pin y is bits 2y+1:2y of offset 0x0C. Code 01 raises `pad_pu[y]` only and code 10 raises `pad_pd[y]` only. Codes 00 and 11 raise neither, so the two pulls are never high together.
- R6: Offset 0x10 returns `pad_in` as it was two clock edges earlier, with bits 31:16 reading zero. Writes to this offset change nothing.
- R7: Offset 0x14 stores output data in bits 15:0 and reads that stored value back, whatever the pin mode. Bits 31:16 ignore writes and read zero. The same holds for bits 31:16 of offset 0x04.
- R8: A write to offset 0x18 sets output bit y where data bit y is 1 and clears it where data bit y+16 is 1. When both bits are 1, the set wins. The offset reads zero.
- R9: A write to offset 0x28 clears output bit y where data bit y is 1 and leaves the rest. The offset reads zero.
- R10: `bus_be[k]` enables data bits 8k+7:8k for every write, including the set/clear and clear-only offsets. Disabled bytes keep their old contents.
- R11: Any address other than 0x00, 0x04, 0x0C, 0x10, 0x14, 0x18, 0x20, 0x24 and 0x28 reads zero, and writes to it change no register.
- R12: `bus_rdata` takes the addressed value on the edge that samples `bus_re` high, and it holds while `bus_re` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW (8) | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write request |
| bus_be | input | 4 | Byte enables for a write |
| bus_re | input | 1 | Read request |
| bus_rdata | output | 32 | Read data, registered |
| pad_in | input | 16 | Pad input levels, asynchronous |
| af_src | input | 256 | Sixteen alternate sources per pin, pin y at bits 16y+15:16y |
| pad_out | output | 16 | Pad output value |
| pad_oe | output | 16 | Pad output enable |
| pad_pu | output | 16 | Pull-up enable |
| pad_pd | output | 16 | Pull-down enable |

## Verification
The properties assume that `bus_we` and `bus_re` are never raised in the same cycle. They also assume that addresses are presented as exact word offsets and that `pad_in` changes away from the clock edge. The stimulus applies every bus signal and pad level half a cycle away from the rising edge and issues only single-direction transfers. It sweeps all mode, pull and selector codes against a running model of the registers.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int PINS = 16;
  localparam int NAF  = 16;
  localparam int AFW  = $clog2(NAF);
  localparam int DW   = 32;

  typedef enum logic [1:0] {
    PM_IN  = 2'b00,
    PM_OUT = 2'b01,
    PM_ALT = 2'b10,
    PM_ANA = 2'b11
  } pin_mode_e;

  localparam logic [7:0] OFS_MODE   = 8'h00;
  localparam logic [7:0] OFS_OTYPE  = 8'h04;
  localparam logic [7:0] OFS_PULL   = 8'h0C;
  localparam logic [7:0] OFS_IDR    = 8'h10;
  localparam logic [7:0] OFS_ODR    = 8'h14;
  localparam logic [7:0] OFS_SETCLR = 8'h18;
  localparam logic [7:0] OFS_AFLO   = 8'h20;
  localparam logic [7:0] OFS_AFHI   = 8'h24;
  localparam logic [7:0] OFS_CLRONLY = 8'h28;

  function automatic logic [DW-1:0] strobe_mask(input logic [DW/8-1:0] be);
    logic [DW-1:0] m;
    for (int k = 0; k < DW/8; k++) m[8*k +: 8] = {8{be[k]}};
    return m;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_port_pkg::*;
(
  input  logic [1:0]     mode,
  input  logic           od,
  input  logic           odr_bit,
  input  logic [AFW-1:0] afsel,
  input  logic [NAF-1:0] af_in,
  input  logic [1:0]     pull,
  output logic           out,
  output logic           oe,
  output logic           pu,
  output logic           pd
);
  logic drive_val;
  logic active;

  always_comb begin
    drive_val = (mode == PM_ALT) ? af_in[afsel] : odr_bit;
    active    = (mode == PM_OUT) || (mode == PM_ALT);
    oe        = active & ~(od & drive_val);
    out       = drive_val & ~od;
    pu        = (pull == 2'b01);
    pd        = (pull == 2'b10);
  end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_port_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  input  logic              we,
  input  logic [DW/8-1:0]   be,
  input  logic              re,
  input  logic [PINS-1:0]   idr,
  output logic [DW-1:0]     rdata,
  output logic [2*PINS-1:0] mode,
  output logic [PINS-1:0]   otype,
  output logic [2*PINS-1:0] pull,
  output logic [DW-1:0]     af_lo,
  output logic [DW-1:0]     af_hi,
  output logic [PINS-1:0]   odr
);
  localparam logic [2*PINS-1:0] MODE_RST = '1;

  logic hit_mode, hit_otype, hit_pull, hit_idr, hit_odr;
  logic hit_setclr, hit_aflo, hit_afhi, hit_clronly;
  assign hit_mode    = (addr == AW'(OFS_MODE));
  assign hit_otype   = (addr == AW'(OFS_OTYPE));
  assign hit_pull    = (addr == AW'(OFS_PULL));
  assign hit_idr     = (addr == AW'(OFS_IDR));
  assign hit_odr     = (addr == AW'(OFS_ODR));
  assign hit_setclr  = (addr == AW'(OFS_SETCLR));
  assign hit_aflo    = (addr == AW'(OFS_AFLO));
  assign hit_afhi    = (addr == AW'(OFS_AFHI));
  assign hit_clronly = (addr == AW'(OFS_CLRONLY));

  logic [DW-1:0]     bmask;
  logic [PINS-1:0]   lo_mask, hi_mask;
  assign bmask   = strobe_mask(be);
  assign lo_mask = bmask[PINS-1:0];
  assign hi_mask = bmask[DW-1:PINS];

  logic [2*PINS-1:0] mode_q, mode_d, pull_q, pull_d;
  logic [PINS-1:0]   otype_q, otype_d, odr_q, odr_d;
  logic [DW-1:0]     aflo_q, aflo_d, afhi_q, afhi_d;
  logic [DW-1:0]     rdata_q, rdata_d;
  logic [PINS-1:0]   set_v, clr_v;
  logic mode_en, otype_en, pull_en, aflo_en, afhi_en, odr_en;

  assign mode_en  = we & hit_mode;
  assign otype_en = we & hit_otype;
  assign pull_en  = we & hit_pull;
  assign aflo_en  = we & hit_aflo;
  assign afhi_en  = we & hit_afhi;
  assign odr_en   = we & (hit_odr | hit_setclr | hit_clronly);

  always_comb begin
    mode_d  = (mode_q  & ~bmask)   | (wdata & bmask);
    pull_d  = (pull_q  & ~bmask)   | (wdata & bmask);
    aflo_d  = (aflo_q  & ~bmask)   | (wdata & bmask);
    afhi_d  = (afhi_q  & ~bmask)   | (wdata & bmask);
    otype_d = (otype_q & ~lo_mask) | (wdata[PINS-1:0] & lo_mask);
    set_v   = '0;
    clr_v   = '0;
    if (hit_setclr) begin
      set_v = wdata[PINS-1:0] & lo_mask;
      clr_v = wdata[DW-1:PINS] & hi_mask;
    end else if (hit_clronly) begin
      clr_v = wdata[PINS-1:0] & lo_mask;
    end
    if (hit_odr) odr_d = (odr_q & ~lo_mask) | (wdata[PINS-1:0] & lo_mask);
    else         odr_d = (odr_q & ~clr_v) | set_v;
  end

  always_comb begin
    rdata_d = '0;
    unique case (1'b1)
      hit_mode:  rdata_d = mode_q;
      hit_otype: rdata_d = {{(DW-PINS){1'b0}}, otype_q};
      hit_pull:  rdata_d = pull_q;
      hit_idr:   rdata_d = {{(DW-PINS){1'b0}}, idr};
      hit_odr:   rdata_d = {{(DW-PINS){1'b0}}, odr_q};
      hit_aflo:  rdata_d = aflo_q;
      hit_afhi:  rdata_d = afhi_q;
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_RST;
      otype_q <= '0;
      pull_q  <= '0;
      aflo_q  <= '0;
      afhi_q  <= '0;
      odr_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (mode_en)  mode_q  <= mode_d;
      if (otype_en) otype_q <= otype_d;
      if (pull_en)  pull_q  <= pull_d;
      if (aflo_en)  aflo_q  <= aflo_d;
      if (afhi_en)  afhi_q  <= afhi_d;
      if (odr_en)   odr_q   <= odr_d;
      if (re)       rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;
  assign mode  = mode_q;
  assign otype = otype_q;
  assign pull  = pull_q;
  assign af_lo = aflo_q;
  assign af_hi = afhi_q;
  assign odr   = odr_q;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int AW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  input  logic                bus_we,
  input  logic [DW/8-1:0]     bus_be,
  input  logic                bus_re,
  output logic [DW-1:0]       bus_rdata,
  input  logic [PINS-1:0]     pad_in,
  input  logic [PINS*NAF-1:0] af_src,
  output logic [PINS-1:0]     pad_out,
  output logic [PINS-1:0]     pad_oe,
  output logic [PINS-1:0]     pad_pu,
  output logic [PINS-1:0]     pad_pd
);
  localparam int HALF = PINS / 2;

  logic [1:0] rst_pipe_q, rst_pipe_d;
  logic       rst_sync_n;
  assign rst_pipe_d = {rst_pipe_q[0], 1'b1};
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= rst_pipe_d;
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [PINS-1:0]   idr_w, otype_w, odr_w;
  logic [2*PINS-1:0] mode_w, pull_w;
  logic [DW-1:0]     aflo_w, afhi_w;

  gpio_in_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(pad_in), .q(idr_w)
  );

  gpio_regfile #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .addr(bus_addr), .wdata(bus_wdata),
    .we(bus_we), .be(bus_be), .re(bus_re), .idr(idr_w), .rdata(bus_rdata),
    .mode(mode_w), .otype(otype_w), .pull(pull_w), .af_lo(aflo_w),
    .af_hi(afhi_w), .odr(odr_w)
  );

  for (genvar y = 0; y < PINS; y++) begin : g_pin
    localparam int FB = (y % HALF) * AFW;
    logic [AFW-1:0] sel;
    if (y < HALF) begin : g_lo
      assign sel = aflo_w[FB +: AFW];
    end else begin : g_hi
      assign sel = afhi_w[FB +: AFW];
    end
    gpio_pin_mux u_mux (
      .mode(mode_w[2*y +: 2]), .od(otype_w[y]), .odr_bit(odr_w[y]),
      .afsel(sel), .af_in(af_src[y*NAF +: NAF]), .pull(pull_w[2*y +: 2]),
      .out(pad_out[y]), .oe(pad_oe[y]), .pu(pad_pu[y]), .pd(pad_pd[y])
    );
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int AW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [AW-1:0]       bus_addr,
  input logic [DW-1:0]       bus_wdata,
  input logic                bus_we,
  input logic [DW/8-1:0]     bus_be,
  input logic                bus_re,
  input logic [DW-1:0]       bus_rdata,
  input logic [PINS-1:0]     pad_in,
  input logic [PINS-1:0]     pad_out,
  input logic [PINS-1:0]     pad_oe,
  input logic [PINS-1:0]     pad_pu,
  input logic [PINS-1:0]     pad_pd,
  input logic [2*PINS-1:0]   mode_q,
  input logic [PINS-1:0]     otype_q,
  input logic [PINS-1:0]     odr_q,
  input logic [PINS-1:0]     idr_q
);
  logic [PINS-1:0] lo_m;
  assign lo_m = {{8{bus_be[1]}}, {8{bus_be[0]}}};

  logic mapped;
  assign mapped = (bus_addr == AW'(OFS_MODE))   || (bus_addr == AW'(OFS_OTYPE)) ||
                  (bus_addr == AW'(OFS_PULL))   || (bus_addr == AW'(OFS_IDR))   ||
                  (bus_addr == AW'(OFS_ODR))    || (bus_addr == AW'(OFS_SETCLR)) ||
                  (bus_addr == AW'(OFS_AFLO))   || (bus_addr == AW'(OFS_AFHI))  ||
                  (bus_addr == AW'(OFS_CLRONLY));

  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R5
  pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_pd) == '0);

  // R4
  od_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & otype_q) == '0);

  // R4
  od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & otype_q & ~pad_out) == (pad_oe & otype_q));

  for (genvar y = 0; y < PINS; y++) begin : g_oe
    // R2
    oe_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[2*y] == mode_q[2*y+1]) |-> !pad_oe[y]);
  end

  // R8
  setclr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(OFS_SETCLR)) |=>
      ((odr_q & $past(bus_wdata[PINS-1:0] & lo_m)) == $past(bus_wdata[PINS-1:0] & lo_m)));

  // R9
  clronly_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(OFS_CLRONLY)) |=>
      ((odr_q & $past(bus_wdata[PINS-1:0] & lo_m)) == '0));

  // R6
  idr_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == AW'(OFS_IDR)) |=> (bus_rdata[DW-1:PINS] == '0));

  // R11
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && !mapped) |=> (bus_rdata == '0));

  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));

  if (SYNC_STAGES == 2) begin : g_sync
    // R6
    sync_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q >= 2'd2) |-> (idr_q == $past(pad_in, 2)));
  end
endmodule

bind gpio_port gpio_port_chk #(.AW(AW), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_be(bus_be), .bus_re(bus_re), .bus_rdata(bus_rdata),
  .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
  .pad_pd(pad_pd), .mode_q(mode_w), .otype_q(otype_w), .odr_q(odr_w),
  .idr_q(idr_w)
);

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
  import gpio_port_pkg::*;
  localparam int AW = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic          bus_we, bus_re;
  logic [3:0]    bus_be;
  logic [15:0]   pad_in, pad_out, pad_oe, pad_pu, pad_pd;
  logic [255:0]  af_src;

  gpio_port #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_be(bus_be), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .af_src(af_src), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .pad_pd(pad_pd)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  logic [31:0] s_mode, s_pull, s_afl, s_afh;
  logic [15:0] s_ot, s_odr;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] bmask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    logic [31:0] m;
    m = bmask(be);
    case (a)
      8'h00: s_mode = (s_mode & ~m) | (d & m);
      8'h04: s_ot   = (s_ot & ~m[15:0]) | (d[15:0] & m[15:0]);
      8'h0C: s_pull = (s_pull & ~m) | (d & m);
      8'h14: s_odr  = (s_odr & ~m[15:0]) | (d[15:0] & m[15:0]);
      8'h18: s_odr  = (s_odr & ~(d[31:16] & m[31:16])) | (d[15:0] & m[15:0]);
      8'h20: s_afl  = (s_afl & ~m) | (d & m);
      8'h24: s_afh  = (s_afh & ~m) | (d & m);
      8'h28: s_odr  = s_odr & ~(d[15:0] & m[15:0]);
      default: ;
    endcase
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h00: return s_mode;
      8'h04: return {16'h0, s_ot};
      8'h0C: return s_pull;
      8'h14: return {16'h0, s_odr};
      8'h20: return s_afl;
      8'h24: return s_afh;
      default: return 32'h0;
    endcase
  endfunction

  // all tasks start and end at a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    model_write(a, d, be);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic set_af(input int seed);
    for (int i = 0; i < 256; i++) af_src[i] = (((i * 5) + (i / 16) * 3 + seed) % 7) < 3;
  endtask

  task automatic check_pins(input string req);
    logic [15:0] e_out, e_oe, e_pu, e_pd;
    for (int y = 0; y < 16; y++) begin
      logic [1:0] md, pl;
      logic [3:0] s;
      logic v;
      md = s_mode[2*y +: 2];
      pl = s_pull[2*y +: 2];
      s  = (y < 8) ? s_afl[4*y +: 4] : s_afh[4*(y-8) +: 4];
      v  = (md == 2'b10) ? af_src[16*y + int'(s)] : s_odr[y];
      e_out[y] = v & ~s_ot[y];
      e_oe[y]  = ((md == 2'b01) || (md == 2'b10)) && !(s_ot[y] && v);
      e_pu[y]  = (pl == 2'b01);
      e_pd[y]  = (pl == 2'b10);
    end
    chk({req, " pad_out"}, {16'h0, pad_out}, {16'h0, e_out});
    chk({req, " pad_oe"},  {16'h0, pad_oe},  {16'h0, e_oe});
    chk({req, " pad_pu"},  {16'h0, pad_pu},  {16'h0, e_pu});
    chk({req, " pad_pd"},  {16'h0, pad_pd},  {16'h0, e_pd});
  endtask

  task automatic check_all_regs(input string req);
    for (int a = 0; a < 64; a += 4) begin
      if (a != 8'h10) rd_chk(req, 8'(a), model_read(8'(a)));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0;
    bus_be = 4'hF; pad_in = '0;
    set_af(0);
    s_mode = 32'hFFFF_FFFF; s_pull = '0; s_afl = '0; s_afh = '0; s_ot = '0; s_odr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state, R11 unmapped zero
    check_pins("R1");
    check_all_regs("R1/R11 reset");
    rd_chk("R1 idr", 8'h10, 32'h0);

    // R2 mode sweep with output data
    for (int c = 0; c < 4; c++) begin
      wr(8'h00, {16{2'(c)}}, 4'hF);
      wr(8'h14, 32'h0000_5A3C, 4'hF);
      check_pins("R2");
      wr(8'h14, 32'h0000_C3A5, 4'hF);
      check_pins("R2");
    end
    wr(8'h00, 32'h1B1B_1B1B, 4'hF);
    check_pins("R2 mixed");

    // R3 alternate select sweep
    wr(8'h00, 32'hAAAA_AAAA, 4'hF);
    for (int seed = 0; seed < 3; seed++) begin
      set_af(seed);
      for (int s = 0; s < 16; s++) begin
        wr(8'h20, 32'h1111_1111 * s, 4'hF);
        wr(8'h24, 32'h1111_1111 * s, 4'hF);
        #1 check_pins("R3");
      end
      wr(8'h20, 32'h7654_3210, 4'hF);
      wr(8'h24, 32'hFEDC_BA98, 4'hF);
      check_pins("R3 per-pin");
    end

    // R4 open-drain
    wr(8'h04, 32'hFFFF_A5A5, 4'hF);
    rd_chk("R7 otype upper", 8'h04, 32'h0000_A5A5);
    foreach (s_mode[i]) ;
    for (int c = 1; c < 3; c++) begin
      wr(8'h00, {16{2'(c)}}, 4'hF);
      wr(8'h14, 32'h0000_0000, 4'hF); check_pins("R4");
      wr(8'h14, 32'h0000_FFFF, 4'hF); check_pins("R4");
      wr(8'h14, 32'h0000_3C0F, 4'hF); check_pins("R4");
    end
    wr(8'h04, 32'h0, 4'hF);

    // R5 pull codes
    for (int c = 0; c < 4; c++) begin
      wr(8'h0C, {16{2'(c)}}, 4'hF);
      check_pins("R5");
    end
    wr(8'h0C, 32'hE4E4_E4E4, 4'hF);
    check_pins("R5 mixed");

    // R6 input path: two-edge latency
    begin
      logic [15:0] prev;
      prev = 16'h0;
      for (int k = 0; k < 6; k++) begin
        logic [15:0] nv;
        nv = 16'(k * 16'h3D59 + 16'h1234);
        pad_in = nv;
        rd_chk("R6 lat1", 8'h10, {16'h0, prev});
        rd_chk("R6 lat2", 8'h10, {16'h0, prev});
        rd_chk("R6 lat3", 8'h10, {16'h0, nv});
        prev = nv;
      end
      wr(8'h10, 32'hFFFF_FFFF, 4'hF);
      rd_chk("R6 ro", 8'h10, {16'h0, prev});
      check_all_regs("R6 write ignored");
    end

    // R7 output data readback
    wr(8'h14, 32'hFFFF_FFFF, 4'hF);
    rd_chk("R7", 8'h14, 32'h0000_FFFF);
    wr(8'h00, 32'h0, 4'hF);
    pad_in = 16'h0;
    repeat (3) @(negedge clk);
    rd_chk("R7 input mode", 8'h14, 32'h0000_FFFF);
    wr(8'h14, 32'h0000_1234, 4'hF);
    rd_chk("R7", 8'h14, 32'h0000_1234);

    // R8 set/clear with set priority
    wr(8'h00, 32'h5555_5555, 4'hF);
    begin
      logic [31:0] pats [6];
      pats[0] = 32'h0000_00F0; pats[1] = 32'h00FF_0000; pats[2] = 32'hFFFF_FFFF;
      pats[3] = 32'hF0F0_0F0F; pats[4] = 32'hFFFF_0000; pats[5] = 32'h1234_8421;
      for (int i = 0; i < 6; i++) begin
        wr(8'h18, pats[i], 4'hF);
        rd_chk("R8", 8'h14, {16'h0, s_odr});
        check_pins("R8");
      end
      rd_chk("R8 reads zero", 8'h18, 32'h0);
    end

    // R9 clear-only
    wr(8'h14, 32'h0000_FFFF, 4'hF);
    wr(8'h28, 32'hFFFF_00F3, 4'hF);
    rd_chk("R9", 8'h14, {16'h0, s_odr});
    wr(8'h28, 32'h0000_8100, 4'hF);
    rd_chk("R9", 8'h14, {16'h0, s_odr});
    rd_chk("R9 reads zero", 8'h28, 32'h0);

    // R10 byte strobes
    for (int be = 0; be < 16; be++) begin
      wr(8'h00, 32'h1357_9BDF ^ (32'h0101_0101 * be), 4'(be));
      rd_chk("R10 mode", 8'h00, s_mode);
      wr(8'h24, 32'hA5C3_3C5A + be, 4'(be));
      rd_chk("R10 afhi", 8'h24, s_afh);
      wr(8'h18, 32'h0F0F_F0F0 ^ (32'h1111_1111 * be), 4'(be));
      rd_chk("R10 setclr", 8'h14, {16'h0, s_odr});
    end

    // R11 unmapped offsets
    wr(8'h08, 32'hFFFF_FFFF, 4'hF);
    wr(8'h1C, 32'hFFFF_FFFF, 4'hF);
    wr(8'h2C, 32'hFFFF_FFFF, 4'hF);
    wr(8'hFC, 32'hFFFF_FFFF, 4'hF);
    wr(8'h15, 32'hFFFF_FFFF, 4'hF);
    check_all_regs("R11");
    rd_chk("R11", 8'hFC, 32'h0);

    // R12 hold while idle
    rd(8'h00, v);
    chk("R12", v, s_mode);
    bus_addr = 8'h14;
    repeat (3) @(negedge clk);
    chk("R12 hold", bus_rdata, s_mode);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule